// File: doc/BRIEF.md
# Reference clock loss supervisor

This block watches a reference clock from a free-running system clock. It decides when the output of a frequency-locked synthesizer must be reported as unlocked, and whether that output clock may keep running. The reference is synchronized and its rising edges are detected. The block counts system cycles since the last edge and measures each edge-to-edge period. A five-state controller (reset, acquire, locked, holdover, unlocked) turns these measurements into an unlock flag and an output enable.

When the reference stops cleanly, the output is held valid for a long fixed timeout before unlock is declared. When the reference glitches or its period jumps, the timeout is skipped and unlock is declared at once. After unlock, a returning reference must stay stable for a programmable lock interval before the flag clears. An outage that is longer than the skip threshold but shorter than the timeout is handled in one of two ways, chosen by a skip-enable input. With skip enabled, it is absorbed silently. With skip disabled, it forces a full relock.

Top module: `ref_loss_supervisor`

## Requirements
- R1: While rst_ni is low, unlock_o is 1 and out_en_o equals unl_run_i.
- R2: After reset, unlock_o stays 1 until two reference edges have given a valid period and LOCK_CYC further cycles have passed with no period change and no gap of TCS_CYC cycles or more. Then unlock_o goes to 0.
- R3: While locked, if the reference stops with no period change, unlock_o stays 0 for TIMEOUT_CYC cycles after the last synchronized rising edge and is then asserted. This holds for both values of skip_en_i.
- R4: While locked, an edge-to-edge period that differs from the previous period by more than PER_TOL (for example a one-cycle high pulse) asserts unlock_o within a few cycles, without waiting for any timeout. This holds for both values of skip_en_i.
- R5: Period differences of PER_TOL cycles or fewer, and duty-cycle changes that keep the period, leave unlock_o at 0.
- R6: While unlock_o is 1, out_en_o equals unl_run_i: 0 stops the output clock, 1 keeps it toggling with its frequency marked invalid. While unlock_o is 0, out_en_o is 1.
- R7: When the reference returns after an unlock, unlock_o stays 1 for the lock interval of R2 and then returns to 0.
- R8: With skip_en_i at 1, a clean outage longer than TCS_CYC and shorter than TIMEOUT_CYC never asserts unlock_o, neither during the outage nor after the reference returns.
- R9: With skip_en_i at 0, the same outage asserts unlock_o when the reference returns. The flag clears only after the lock interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to clk_i |
| skip_en_i | input | 1 | 1: absorb medium outages without unlock |
| unl_run_i | input | 1 | 1: output keeps running while unlocked |
| unlock_o | output | 1 | Unlock flag, 1 when the output frequency is not trusted |
| out_en_o | output | 1 | Enable for the synthesized output clock |

## Verification
The bench builds the block with TIMEOUT_CYC=400, TCS_CYC=40, LOCK_CYC=100 and PER_TOL=1, against a reference period of 10 system cycles. With these values a full timeout, each relock and both outage classes fit in a few hundred cycles, so every state transition runs several times. A one-cycle difference in period sits exactly at the tolerance limit. A two-cycle difference sits just past it.

// File: rtl/ref_sup_pkg.sv
package ref_sup_pkg;
  typedef enum logic [2:0] {
    ST_RESET,
    ST_ACQUIRE,
    ST_LOCKED,
    ST_HOLDOVER,
    ST_UNLOCKED
  } sup_state_e;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= ref_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES-1];

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

  // R4
  edge_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ref_period_meter.sv
module ref_period_meter #(
  parameter int TIMEOUT_CYC = 1 << 23,
  parameter int TCS_CYC     = 4096,
  parameter int PER_TOL     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic stale_o,
  output logic timeout_o,
  output logic valid_o,
  output logic change_o
);
  localparam int GAP_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(TIMEOUT_CYC);
  localparam logic [GAP_W-1:0] GAP_TCS = GAP_W'(TCS_CYC);
  localparam logic [GAP_W:0]   TOL_V   = (GAP_W+1)'(PER_TOL);

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W:0]   prev_q, cur, diff;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               gap_q <= '0;
    else if (rise_i)           gap_q <= '0;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;

  assign stale_o   = gap_q >= GAP_TCS;
  assign timeout_o = gap_q == GAP_MAX;
  assign cur       = {1'b0, gap_q} + 1'b1;
  assign diff      = (cur > prev_q) ? cur - prev_q : prev_q - cur;
  assign change_o  = rise_i && valid_q && !stale_o && (diff > TOL_V);
  assign valid_o   = valid_q;

  // a period that ends a long gap is not a reference for the next one
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_q <= 1'b0;
      prev_q  <= '0;
    end else if (rise_i && !stale_o) begin
      valid_q <= 1'b1;
      prev_q  <= cur;
    end else if (stale_o) begin
      valid_q <= 1'b0;
    end

  // R3
  gap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !rise_i |=> timeout_o);

  // R9
  stale_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_o |=> !valid_o);
endmodule

// File: rtl/ref_lock_fsm.sv
module ref_lock_fsm
  import ref_sup_pkg::*;
#(
  parameter int LOCK_CYC = 65536
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       stale_i,
  input  logic       timeout_i,
  input  logic       valid_i,
  input  logic       change_i,
  input  logic       skip_en_i,
  output sup_state_e state_o
);
  localparam int LOCK_W = $clog2(LOCK_CYC);
  localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_CYC - 1);

  sup_state_e       st_q, st_d;
  logic [LOCK_W-1:0] lock_q;
  logic              relock, steady, lock_done;

  assign relock    = (st_q == ST_ACQUIRE) || (st_q == ST_UNLOCKED);
  assign steady    = valid_i && !stale_i && !change_i;
  assign lock_done = steady && (lock_q == LOCK_LAST);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RESET:    st_d = ST_ACQUIRE;
      ST_ACQUIRE,
      ST_UNLOCKED: if (lock_done) st_d = ST_LOCKED;
      ST_LOCKED:   if (change_i)     st_d = ST_UNLOCKED;
                   else if (stale_i) st_d = ST_HOLDOVER;
      ST_HOLDOVER: if (rise_i)         st_d = skip_en_i ? ST_LOCKED : ST_UNLOCKED;
                   else if (timeout_i) st_d = ST_UNLOCKED;
      default:     st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_RESET;
    else         st_q <= st_d;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 lock_q <= '0;
    else if (!relock || !steady) lock_q <= '0;
    else if (!lock_done)         lock_q <= lock_q + 1'b1;

  assign state_o = st_q;

  // R2
  lock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCKED) && (($past(st_q) == ST_ACQUIRE) || ($past(st_q) == ST_UNLOCKED))
    |-> $past(lock_q) == LOCK_LAST);

  // R4
  glitch_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCKED) && change_i |=> st_q == ST_UNLOCKED);

  // R3
  holdover_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLDOVER) && timeout_i |=> st_q != ST_HOLDOVER);

  // R8
  skip_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLDOVER) && rise_i && skip_en_i |=> st_q == ST_LOCKED);
endmodule

// File: rtl/ref_loss_supervisor.sv
module ref_loss_supervisor
  import ref_sup_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1 << 23,
  parameter int TCS_CYC     = 4096,
  parameter int LOCK_CYC    = 65536,
  parameter int PER_TOL     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic skip_en_i,
  input  logic unl_run_i,
  output logic unlock_o,
  output logic out_en_o
);
  logic       rise, stale, timeout, valid, change;
  sup_state_e state;

  ref_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_clk_i),
    .rise_o (rise)
  );

  ref_period_meter #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .TCS_CYC     (TCS_CYC),
    .PER_TOL     (PER_TOL)
  ) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .stale_o   (stale),
    .timeout_o (timeout),
    .valid_o   (valid),
    .change_o  (change)
  );

  ref_lock_fsm #(.LOCK_CYC(LOCK_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .stale_i   (stale),
    .timeout_i (timeout),
    .valid_i   (valid),
    .change_i  (change),
    .skip_en_i (skip_en_i),
    .state_o   (state)
  );

  assign unlock_o = (state != ST_LOCKED) && (state != ST_HOLDOVER);
  assign out_en_o = !unlock_o || unl_run_i;

  // R6
  out_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_o |-> unlock_o && !unl_run_i);
endmodule

// File: tb/ref_loss_supervisor_test.sv
module ref_loss_supervisor_test;
  localparam int TO   = 400;
  localparam int TCS  = 40;
  localparam int LOCK = 100;
  localparam int TOL  = 1;

  // {hi, lo, count, skip, run, exp_unlock, exp_out_en}
  typedef struct packed {
    int hi; int lo; int n;
    bit skip; bit run; bit exp_unl; bit exp_en;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{5, 5, 10, 1'b0, 1'b0, 1'b0, 1'b1},
    '{5, 6, 1,  1'b0, 1'b0, 1'b0, 1'b1},
    '{5, 5, 5,  1'b0, 1'b0, 1'b0, 1'b1},
    '{5, 4, 1,  1'b1, 1'b1, 1'b0, 1'b1},
    '{5, 5, 5,  1'b1, 1'b1, 1'b0, 1'b1},
    '{4, 6, 3,  1'b0, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, ref_clk, skip_en, unl_run;
  logic unlock, out_en;
  int   total = 0, bad = 0, unl_seen = 0;
  bit   mon_en = 1'b0;

  always #4 clk = ~clk;

  ref_loss_supervisor #(
    .TIMEOUT_CYC (TO),
    .TCS_CYC     (TCS),
    .LOCK_CYC    (LOCK),
    .PER_TOL     (TOL),
    .SYNC_STAGES (2)
  ) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ref_clk_i (ref_clk),
    .skip_en_i (skip_en),
    .unl_run_i (unl_run),
    .unlock_o  (unlock),
    .out_en_o  (out_en)
  );

  always @(negedge clk) if (mon_en && unlock) unl_seen++;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulses(int hi, int lo, int n);
    for (int i = 0; i < n; i++) begin
      ref_clk = 1'b1;
      repeat (hi) @(negedge clk);
      ref_clk = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    ref_clk = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_clk = 1'b0; skip_en = 1'b0; unl_run = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 unlock in reset", int'(unlock), 1);
    chk("R1 out_en follows run=0", int'(out_en), 0);
    unl_run = 1'b1;
    @(negedge clk);
    chk("R1 out_en follows run=1", int'(out_en), 1);
    unl_run = 1'b0;
    rst_n = 1'b1;

    // acquire
    pulses(5, 5, 5);
    chk("R2 still acquiring", int'(unlock), 1);
    pulses(5, 5, 15);
    chk("R2 locked", int'(unlock), 0);

    // table: locked with jitter, duty and configuration changes
    foreach (VECS[k]) begin
      skip_en = VECS[k].skip;
      unl_run = VECS[k].run;
      pulses(VECS[k].hi, VECS[k].lo, VECS[k].n);
      chk("R5 tolerated period", int'(unlock), int'(VECS[k].exp_unl));
      chk("R6 out_en while locked", int'(out_en), int'(VECS[k].exp_en));
    end

    // clean removal, skip off
    skip_en = 1'b0; unl_run = 1'b0;
    idle(TO - 30);
    chk("R3 holdover before timeout", int'(unlock), 0);
    chk("R3 output kept in holdover", int'(out_en), 1);
    idle(50);
    chk("R3 unlock after timeout", int'(unlock), 1);
    chk("R6 output stopped when unlocked", int'(out_en), 0);
    unl_run = 1'b1;
    @(negedge clk);
    chk("R6 output runs when unlocked", int'(out_en), 1);
    unl_run = 1'b0;
    pulses(5, 5, 5);
    chk("R7 unlock during lock time", int'(unlock), 1);
    pulses(5, 5, 15);
    chk("R7 relocked", int'(unlock), 0);

    // clean removal, skip on
    skip_en = 1'b1;
    idle(TO - 30);
    chk("R3 skip=1 before timeout", int'(unlock), 0);
    idle(50);
    chk("R3 skip=1 after timeout", int'(unlock), 1);
    pulses(5, 5, 20);
    chk("R7 relocked after skip timeout", int'(unlock), 0);

    // medium outage, skip on
    unl_seen = 0;
    mon_en = 1'b1;
    idle(150);
    pulses(5, 5, 20);
    mon_en = 1'b0;
    chk("R8 no unlock over medium outage", unl_seen, 0);

    // medium outage, skip off
    skip_en = 1'b0;
    idle(150);
    pulses(5, 5, 3);
    chk("R9 unlock after medium outage", int'(unlock), 1);
    pulses(5, 5, 20);
    chk("R9 relocked after lock time", int'(unlock), 0);

    // glitch at removal, skip off then on
    pulses(5, 1, 1);
    pulses(1, 1, 1);
    idle(10);
    chk("R4 glitch unlock skip=0", int'(unlock), 1);
    pulses(5, 5, 20);
    chk("R7 relocked after glitch", int'(unlock), 0);
    skip_en = 1'b1;
    pulses(5, 1, 1);
    pulses(1, 1, 1);
    idle(10);
    chk("R4 glitch unlock skip=1", int'(unlock), 1);
    pulses(5, 5, 20);
    chk("R7 relocked after second glitch", int'(unlock), 0);

    // period step just beyond tolerance
    skip_en = 1'b0;
    pulses(5, 7, 1);
    pulses(5, 5, 1);
    chk("R5 period step beyond tolerance", int'(unlock), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule